// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block keeps one pending flag for each of twelve asynchronous interrupt sources of a processor core. Timers, external pins and other producers raise or drop flags through per-source set and clear vectors. Doorbell messages also raise or drop flags through a small decoder that reads a message type, a broadcast bit and a target tag. When the core signals that it can take an interrupt, the block picks at most one eligible source and presents it one cycle later to the exception entry logic. The source is given both as a one-hot vector and as a 4-bit code, together with a valid strobe.

Eligibility works in three tiers. System reset and machine check are always eligible. The critical external input needs the critical-enable bit. Every other source needs the external-enable bit. Most sources are consumed when they are taken. The two level-sensitive external inputs stay pending until their producer clears them.

Top module: `irq_prio_sel`

## Requirements
- R1: While reset is held, `pend_o`, `irq_valid_o`, `irq_onehot_o` and `irq_code_o` are all zero.
- R2: Source codes run in fixed priority order, where a lower code wins. The codes are: 0 system reset, 1 machine check, 2 critical external, 3 watchdog, 4 critical doorbell, 5 fixed-interval timer, 6 programmable-interval timer, 7 decrementer, 8 external input, 9 doorbell, 10 performance monitor, 11 thermal. Flag bit k of every vector belongs to code k.
- R3: Codes 0 and 1 are delivered whatever the values of `msr_ce_i` and `msr_ee_i`.
- R4: Code 2 is eligible only while `msr_ce_i` is 1.
- R5: Codes 3 to 11 are eligible only while `msr_ee_i` is 1.
- R6: Delivering code 2 or code 8 leaves its pending flag set.
- R7: Delivering any other code clears its pending flag at the same clock edge that registers the delivery.
- R8: At most one source is delivered per step. `irq_onehot_o` has exactly one bit set when `irq_valid_o` is 1, and that bit matches `irq_code_o`. When no pending source is eligible, `irq_valid_o` stays 0 and the code and one-hot outputs read zero.
- R9: A doorbell clear with message type 0 drops flag 9, and one with type 1 drops flag 4. Any other type changes nothing.
- R10: A doorbell send with type 0 or 1 raises flag 9 or flag 4 respectively. It does so only when `db_bcast_i` is 1 or `db_tag_i` equals `core_id_i`. Other types, or a tag mismatch without broadcast, change nothing.
- R11: When a flag is set in the same cycle that it is cleared or consumed, it ends up set.
- R12: `irq_valid_o` is 1 only in the cycle that follows a cycle with `take_i` high. The selection uses the flags and enables present in the cycle of `take_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_i | input | 12 | Per-source raise request |
| clr_i | input | 12 | Per-source drop request |
| take_i | input | 1 | Core can accept an interrupt this cycle |
| msr_ce_i | input | 1 | Critical interrupt enable |
| msr_ee_i | input | 1 | External interrupt enable |
| db_snd_i | input | 1 | Doorbell send strobe |
| db_clr_i | input | 1 | Doorbell clear strobe |
| db_type_i | input | TYPE_W | Doorbell message type |
| db_bcast_i | input | 1 | Doorbell broadcast bit |
| db_tag_i | input | ID_W | Doorbell target tag |
| core_id_i | input | ID_W | This core's identifier |
| pend_o | output | 12 | Current pending flags |
| irq_valid_o | output | 1 | Delivery strobe |
| irq_onehot_o | output | 12 | Delivered source, one-hot |
| irq_code_o | output | 4 | Delivered source, encoded |

## Verification
The assertions assume that `rst_n` is held low for at least two clock edges, so the reset synchronizer has settled before any set or take request arrives. They also assume the enables are stable in the cycle of a take. The bench drives all inputs on the falling edge and starts stimulus only several cycles after reset release. It sweeps every pending pattern under each of the four enable combinations, with flags loaded through the ordinary set and clear ports.

// File: rtl/irq_sel_pkg.sv
`timescale 1ns/1ps
package irq_sel_pkg;
  localparam int NSRC   = 12;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    SRC_SYSRST = 4'd0,  SRC_MCHK  = 4'd1,  SRC_CEXT  = 4'd2,  SRC_WDOG  = 4'd3,
    SRC_CDBELL = 4'd4,  SRC_FIXT  = 4'd5,  SRC_PIT   = 4'd6,  SRC_DECR  = 4'd7,
    SRC_EXT    = 4'd8,  SRC_DBELL = 4'd9,  SRC_PERF  = 4'd10, SRC_THERM = 4'd11
  } src_e;

  // Tier masks: bit k belongs to code k
  localparam logic [NSRC-1:0] TIER_ALWAYS = 12'h003;
  localparam logic [NSRC-1:0] TIER_CRIT   = 12'h004;
  localparam logic [NSRC-1:0] TIER_EXTEN  = 12'hFF8;
  // Level-sensitive sources that survive delivery
  localparam logic [NSRC-1:0] KEEP_ON_TAKE = 12'h104;
endpackage

// File: rtl/irq_db_decode.sv
`timescale 1ns/1ps
module irq_db_decode
  import irq_sel_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int ID_W   = 8
) (
  input  logic              snd_i,
  input  logic              clr_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              bcast_i,
  input  logic [ID_W-1:0]   tag_i,
  input  logic [ID_W-1:0]   core_id_i,
  output logic [NSRC-1:0]   set_o,
  output logic [NSRC-1:0]   clr_o
);
  localparam logic [TYPE_W-1:0] MSG_NORM = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] MSG_CRIT = TYPE_W'(1);

  logic [NSRC-1:0] tgt;
  logic            hit;

  always_comb begin
    tgt = '0;
    if (type_i == MSG_NORM) tgt[SRC_DBELL]  = 1'b1;
    if (type_i == MSG_CRIT) tgt[SRC_CDBELL] = 1'b1;
    hit   = bcast_i | (tag_i == core_id_i);
    set_o = (snd_i && hit) ? tgt : '0;
    clr_o = clr_i ? tgt : '0;
  end
endmodule

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg
  import irq_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] eat_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, pend_d, en;

  for (genvar k = 0; k < NSRC; k++) begin : g_bit
    always_comb begin
      en[k]     = set_i[k] | clr_i[k] | eat_i[k];
      pend_d[k] = set_i[k] | (pend_q[k] & ~clr_i[k] & ~eat_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q[k] <= 1'b0;
      else if (en[k]) pend_q[k] <= pend_d[k];
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> pend_q[k]);

    if (KEEP_ON_TAKE[k]) begin : g_keep
      assert_level_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[k] && !clr_i[k]) |=> pend_q[k]);
    end else begin : g_eat
      assert_eaten_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eat_i[k] && !set_i[k]) |=> !pend_q[k]);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_sel_pkg::*;
(
  input  logic [NSRC-1:0]   pend_i,
  input  logic              ce_i,
  input  logic              ee_i,
  output logic [NSRC-1:0]   grant_o,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  logic [NSRC-1:0] elig;

  always_comb begin
    elig = pend_i & (TIER_ALWAYS | (ce_i ? TIER_CRIT : '0) | (ee_i ? TIER_EXTEN : '0));
    grant_o = '0;
    code_o  = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (elig[k]) begin
        grant_o = '0;
        grant_o[k] = 1'b1;
        code_o  = CODE_W'(k);
      end
    end
    any_o = |elig;
  end

  always_comb begin
    assert_single_grant_R8: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       set_i,
  input  logic [11:0]       clr_i,
  input  logic              take_i,
  input  logic              msr_ce_i,
  input  logic              msr_ee_i,
  input  logic              db_snd_i,
  input  logic              db_clr_i,
  input  logic [TYPE_W-1:0] db_type_i,
  input  logic              db_bcast_i,
  input  logic [ID_W-1:0]   db_tag_i,
  input  logic [ID_W-1:0]   core_id_i,
  output logic [11:0]       pend_o,
  output logic              irq_valid_o,
  output logic [11:0]       irq_onehot_o,
  output logic [3:0]        irq_code_o
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [NSRC-1:0]   db_set, db_clr, pend, grant, eat;
  logic [CODE_W-1:0] code;
  logic              any;

  irq_db_decode #(.TYPE_W(TYPE_W), .ID_W(ID_W)) u_db (
    .snd_i(db_snd_i), .clr_i(db_clr_i), .type_i(db_type_i), .bcast_i(db_bcast_i),
    .tag_i(db_tag_i), .core_id_i(core_id_i), .set_o(db_set), .clr_o(db_clr));

  irq_arbiter u_arb (
    .pend_i(pend), .ce_i(msr_ce_i), .ee_i(msr_ee_i),
    .grant_o(grant), .code_o(code), .any_o(any));

  assign eat = take_i ? (grant & ~KEEP_ON_TAKE) : '0;

  irq_pend_reg u_pend (
    .clk(clk), .rst_n(rst_sn), .set_i(set_i | db_set), .clr_i(clr_i | db_clr),
    .eat_i(eat), .pend_o(pend));

  // delivery register
  logic              vld_q, vld_d;
  logic [NSRC-1:0]   oh_q, oh_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              out_en;

  always_comb begin
    out_en = take_i | vld_q;
    vld_d  = take_i & any;
    oh_d   = take_i ? grant : '0;
    code_d = take_i ? code  : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q  <= 1'b0;
      oh_q   <= '0;
      code_q <= '0;
    end else if (out_en) begin
      vld_q  <= vld_d;
      oh_q   <= oh_d;
      code_q <= code_d;
    end
  end

  assign pend_o       = pend;
  assign irq_valid_o  = vld_q;
  assign irq_onehot_o = oh_q;
  assign irq_code_o   = code_q;

  assert_sysrst_first_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (take_i && pend_o[0]) |=> (irq_valid_o && irq_code_o == 4'd0));
  assert_mchk_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (take_i && !pend_o[0] && pend_o[1]) |=> (irq_valid_o && irq_code_o == 4'd1));
  assert_crit_gate_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (take_i && !msr_ce_i) |=> !irq_onehot_o[2]);
  assert_ext_gate_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (take_i && !msr_ee_i) |=> (irq_onehot_o[11:3] == 9'd0));
  assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_valid_o == ($countones(irq_onehot_o) == 1));
  assert_no_take_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    !take_i |=> !irq_valid_o);
endmodule

// File: tb/sim_irq_prio_sel.sv
`timescale 1ns/1ps
module sim_irq_prio_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] set_i, clr_i;
  logic        take_i, msr_ce_i, msr_ee_i;
  logic        db_snd_i, db_clr_i, db_bcast_i;
  logic [2:0]  db_type_i;
  logic [7:0]  db_tag_i, core_id_i;
  logic [11:0] pend_o, irq_onehot_o;
  logic        irq_valid_o;
  logic [3:0]  irq_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_prio_sel u0 (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i), .take_i(take_i),
    .msr_ce_i(msr_ce_i), .msr_ee_i(msr_ee_i), .db_snd_i(db_snd_i), .db_clr_i(db_clr_i),
    .db_type_i(db_type_i), .db_bcast_i(db_bcast_i), .db_tag_i(db_tag_i),
    .core_id_i(core_id_i), .pend_o(pend_o), .irq_valid_o(irq_valid_o),
    .irq_onehot_o(irq_onehot_o), .irq_code_o(irq_code_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [11:0] p, input bit ce, input bit ee);
    for (int k = 0; k < 12; k++) begin
      if (p[k] && (k < 2 || (k == 2 && ce) || (k >= 3 && ee))) return k;
    end
    return -1;
  endfunction

  task automatic idle();
    set_i = '0; clr_i = '0; take_i = 1'b0; db_snd_i = 1'b0; db_clr_i = 1'b0;
    db_bcast_i = 1'b0; db_type_i = '0; db_tag_i = '0;
  endtask

  task automatic load(input logic [11:0] p);
    @(negedge clk); idle(); set_i = p; clr_i = '1;
    @(negedge clk); idle();
  endtask

  task automatic doorbell(input bit snd, input logic [2:0] ty, input bit bc, input logic [7:0] tag);
    @(negedge clk); idle();
    db_snd_i = snd; db_clr_i = !snd; db_type_i = ty; db_bcast_i = bc; db_tag_i = tag;
    @(negedge clk); idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(); msr_ce_i = 1'b0; msr_ee_i = 1'b0; core_id_i = 8'h5A;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pend_o == 0 && !irq_valid_o && irq_onehot_o == 0 && irq_code_o == 0, "R1 reset",
        {pend_o, irq_onehot_o, irq_code_o, 3'b0, irq_valid_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2..R8 exhaustive sweep over pending patterns and enables
    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 4096; p++) begin
        logic [11:0] pv, ep;
        int w;
        bit ce, ee;
        pv = 12'(p); ce = e[1]; ee = e[0];
        load(pv);
        msr_ce_i = ce; msr_ee_i = ee; take_i = 1'b1;
        @(negedge clk); take_i = 1'b0;
        w = pick(pv, ce, ee);
        if (w < 0) begin
          chk(!irq_valid_o && irq_onehot_o == 0 && irq_code_o == 0, "R8 nothing eligible",
              {irq_onehot_o, irq_code_o, irq_valid_o}, 0);
          chk(pend_o == pv, "R5 masked flags kept", pend_o, pv);
        end else begin
          chk(irq_valid_o && irq_code_o == 4'(w) && irq_onehot_o == (12'd1 << w),
              w < 2 ? "R3 order" : (w == 2 ? "R4 order" : "R2 R5 order"),
              {irq_onehot_o, irq_code_o, irq_valid_o}, {12'd1 << w, 4'(w), 1'b1});
          ep = (w == 2 || w == 8) ? pv : (pv & ~(12'd1 << w));
          chk(pend_o == ep, (w == 2 || w == 8) ? "R6 level kept" : "R7 consumed", pend_o, ep);
        end
      end
    end

    // R12 valid lasts one cycle
    load(12'h080); msr_ee_i = 1'b1; take_i = 1'b1;
    @(negedge clk); take_i = 1'b0;
    chk(irq_valid_o && irq_code_o == 4'd7, "R12 valid after take", irq_code_o, 7);
    @(negedge clk);
    chk(!irq_valid_o, "R12 valid drops", irq_valid_o, 0);
    load(12'h001);
    repeat (2) @(negedge clk);
    chk(!irq_valid_o && pend_o == 12'h001, "R12 no take no delivery", pend_o, 12'h001);

    // R11 set wins over clear and over consume
    @(negedge clk); idle(); set_i = 12'h080; clr_i = 12'h080;
    @(negedge clk); idle();
    chk(pend_o[7], "R11 set over clear", pend_o, 12'h081);
    load(12'h080); msr_ee_i = 1'b1; take_i = 1'b1; set_i = 12'h080;
    @(negedge clk); idle();
    chk(irq_code_o == 4'd7 && pend_o == 12'h080, "R11 set over consume", pend_o, 12'h080);

    // R10 doorbell send
    load(12'h000);
    doorbell(1'b1, 3'd0, 1'b0, 8'h5A);
    chk(pend_o == 12'h200, "R10 tag match normal", pend_o, 12'h200);
    doorbell(1'b1, 3'd1, 1'b0, 8'h11);
    chk(pend_o == 12'h200, "R10 tag mismatch ignored", pend_o, 12'h200);
    doorbell(1'b1, 3'd1, 1'b1, 8'h11);
    chk(pend_o == 12'h210, "R10 broadcast critical", pend_o, 12'h210);
    load(12'h000);
    doorbell(1'b1, 3'd2, 1'b1, 8'h5A);
    chk(pend_o == 12'h000, "R10 unknown type ignored", pend_o, 0);

    // R9 doorbell clear
    load(12'hFFF);
    doorbell(1'b0, 3'd1, 1'b0, 8'h00);
    chk(pend_o == 12'hFEF, "R9 clear critical only", pend_o, 12'hFEF);
    doorbell(1'b0, 3'd5, 1'b0, 8'h00);
    chk(pend_o == 12'hFEF, "R9 unknown type ignored", pend_o, 12'hFEF);
    doorbell(1'b0, 3'd0, 1'b1, 8'h00);
    chk(pend_o == 12'hDEF, "R9 clear normal only", pend_o, 12'hDEF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule